// File: doc/BRIEF.md
# Interrupt Context Switch Engine

This block carries out the hardware state swap that follows an interrupt grant. Instead of executing an instruction stored at the vector location, the engine reads a vector word there. The vector word holds two physical pointers. The engine stores the running processor state as a context word through the first pointer. It then fetches a replacement context word through the second pointer and hands its PC, its flags and, optionally, a new accumulator-block select to the processor in a single cycle. A handler can therefore own a private register block and skip saving and restoring registers.

The same engine also serves two return operations. Each one fetches a context word from a supplied address and applies it. The dismissing variant also names the highest-priority active interrupt level to be cleared. All memory traffic goes through one shared request/acknowledge port, and only one transaction is outstanding at a time. Vector words have one format, whether they come from the fixed per-level table or from a per-device vector array.

Bit numbering below uses a 36-bit word `w[35:0]`.

Top module: `ctxsw_engine`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `ctx_load` and `pi_clear` are all low.
- R2: After an accepted `int_grant`, the first memory transaction is a read (`mem_we`=0) at `int_vec_addr`.
- R3: The second transaction is a write to the vector word's save pointer `w[35:18]`. The data written is the context word {`cur_flags` in w[35:22], valid=1 in w[21], `cur_blk` in w[20:18], `cur_pc` in w[17:0]}, sampled when the grant is accepted.
- R4: The third transaction is a read at the vector word's load pointer `w[17:0]`.
- R5: Once the new-context read is acknowledged, `ctx_load` pulses for exactly one cycle. `ctx_pc` and `ctx_flags` then show w[17:0] and w[35:22] of the word read. The context outputs change only on that load.
- R6: If loaded w[21] is 1, `ctx_blk` becomes w[20:18]. If it is 0, `ctx_blk` equals `cur_blk`.
- R7: A plain restore (`ctx_restore`=1, `ctx_dismiss`=0) makes one read at `ctx_restore_addr`, applies the word as in R5/R6, and leaves `pi_clear` at zero.
- R8: A dismissing restore drives `pi_clear`, during the `ctx_load` cycle, with a one-hot mask of the lowest-index set bit of `pi_in_prog` (bit 0 is the highest priority). It drives zero if no bit is set. At all other times `pi_clear` is zero.
- R9: `busy` is high from the cycle after an operation is accepted through the `ctx_load` cycle, and low when idle.
- R10: A grant that arrives while busy is held and served after the engine returns to idle. Its vector address is kept.
- R11: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_grant | input | 1 | One-cycle interrupt grant |
| int_vec_addr | input | 18 | Physical address of the vector word |
| ctx_restore | input | 1 | One-cycle restore request |
| ctx_dismiss | input | 1 | With `ctx_restore`: also dismiss the active level |
| ctx_restore_addr | input | 18 | Physical address of the context word to restore |
| cur_flags | input | 14 | Running PC flags |
| cur_pc | input | 18 | Running PC |
| cur_blk | input | 3 | Running accumulator block |
| pi_in_prog | input | LEVELS | Interrupt levels in progress, bit 0 highest |
| busy | output | 1 | Engine running a sequence |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Memory address |
| mem_wdata | output | 36 | Memory write data |
| mem_rdata | input | 36 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| ctx_load | output | 1 | New context apply strobe |
| ctx_flags | output | 14 | Flags to load |
| ctx_pc | output | 18 | PC to load |
| ctx_blk | output | 3 | Accumulator block to load |
| pi_clear | output | LEVELS | One-hot level to clear on dismiss |

## Verification
The bench logs every memory transaction and checks the order of the swap steps: vector read, then save write, then new-context read. A design that swapped the halves of the vector word, or that read before writing, would show up as a wrong address or direction in that log. Loaded words with the valid bit set and with it clear catch a design that always switches blocks or never does. A dismiss with several levels in progress, and one with none, catches a wrong priority order or a stray clear. A second grant issued mid-sequence, under slow acknowledges, catches a dropped grant, a lost vector address, or an address that changes while a transaction is stalled.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  localparam int WORD_W = 36;
  localparam int ADDR_W = 18;
  localparam int FLAG_W = 14;
  localparam int BLK_W  = 3;
  localparam int VALID_BIT = ADDR_W + BLK_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_VEC, ST_WR_SAVE, ST_RD_NEW, ST_APPLY
  } ctx_state_e;

  function automatic logic [WORD_W-1:0] ctx_pack(
    input logic [FLAG_W-1:0] flags,
    input logic [BLK_W-1:0]  blk,
    input logic [ADDR_W-1:0] pc);
    return {flags, 1'b1, blk, pc};
  endfunction
endpackage

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_int,
  input  logic       go_rst,
  input  logic       ack,
  output ctx_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (go_int) state <= ST_RD_VEC;
                    else if (go_rst) state <= ST_RD_NEW;
        ST_RD_VEC:  if (ack) state <= ST_WR_SAVE;
        ST_WR_SAVE: if (ack) state <= ST_RD_NEW;
        ST_RD_NEW:  if (ack) state <= ST_APPLY;
        ST_APPLY:   state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // R5: the apply step lasts one cycle
  a_r5_apply_once: assert property (@(posedge clk) disable iff (rst)
    state == ST_APPLY |=> state == ST_IDLE);
  // R4: the save write always precedes the new-context read
  a_r4_save_then_load: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR_SAVE && ack) |=> state == ST_RD_NEW);
endmodule

// File: rtl/ctxsw_prio.sv
module ctxsw_prio #(
  parameter int LEVELS = 7
) (
  input  logic [LEVELS-1:0] active,
  output logic [LEVELS-1:0] first
);
  logic [LEVELS:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign first[g]  = active[g] & ~seen[g];
    assign seen[g+1] = seen[g] | active[g];
  end
endmodule

// File: rtl/ctxsw_engine.sv
module ctxsw_engine
  import ctxsw_pkg::*;
#(
  parameter int LEVELS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_grant,
  input  logic [17:0]       int_vec_addr,
  input  logic              ctx_restore,
  input  logic              ctx_dismiss,
  input  logic [17:0]       ctx_restore_addr,
  input  logic [13:0]       cur_flags,
  input  logic [17:0]       cur_pc,
  input  logic [2:0]        cur_blk,
  input  logic [LEVELS-1:0] pi_in_prog,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [17:0]       mem_addr,
  output logic [35:0]       mem_wdata,
  input  logic [35:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              ctx_load,
  output logic [13:0]       ctx_flags,
  output logic [17:0]       ctx_pc,
  output logic [2:0]        ctx_blk,
  output logic [LEVELS-1:0] pi_clear
);
  ctx_state_e state;
  logic go_int, go_rst;
  logic pend_int, pend_rst, pend_dis;
  logic [ADDR_W-1:0] pend_vaddr, pend_raddr, new_ptr;
  logic [ADDR_W-1:0] vaddr_sel, raddr_sel;
  logic dis_sel, dis_r;
  logic [LEVELS-1:0] first_lvl;
  logic new_ack;

  assign go_int    = (state == ST_IDLE) && (int_grant || pend_int);
  assign go_rst    = (state == ST_IDLE) && !go_int && (ctx_restore || pend_rst);
  assign vaddr_sel = pend_int ? pend_vaddr : int_vec_addr;
  assign raddr_sel = pend_rst ? pend_raddr : ctx_restore_addr;
  assign dis_sel   = pend_rst ? pend_dis : ctx_dismiss;
  assign new_ack   = (state == ST_RD_NEW) && mem_ack;

  ctxsw_seq u_seq (
    .clk(clk), .rst(rst), .go_int(go_int), .go_rst(go_rst),
    .ack(mem_ack), .state(state)
  );

  ctxsw_prio #(.LEVELS(LEVELS)) u_prio (
    .active(pi_in_prog), .first(first_lvl)
  );

  assign busy     = (state != ST_IDLE);
  assign mem_req  = (state == ST_RD_VEC) || (state == ST_WR_SAVE) || (state == ST_RD_NEW);
  assign ctx_load = (state == ST_APPLY);

  // Held requests: at most one grant and one restore wait while busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_int   <= 1'b0;
      pend_rst   <= 1'b0;
      pend_dis   <= 1'b0;
      pend_vaddr <= '0;
      pend_raddr <= '0;
    end else begin
      if (int_grant) pend_vaddr <= int_vec_addr;
      pend_int <= go_int ? (pend_int & int_grant) : (pend_int | int_grant);
      if (ctx_restore) begin
        pend_raddr <= ctx_restore_addr;
        pend_dis   <= ctx_dismiss;
      end
      pend_rst <= go_rst ? (pend_rst & ctx_restore) : (pend_rst | ctx_restore);
    end
  end

  // Memory port and context datapath.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      new_ptr   <= '0;
      dis_r     <= 1'b0;
      ctx_flags <= '0;
      ctx_pc    <= '0;
      ctx_blk   <= '0;
      pi_clear  <= '0;
    end else begin
      pi_clear <= '0;
      if (go_int) begin
        mem_addr  <= vaddr_sel;
        mem_we    <= 1'b0;
        mem_wdata <= ctx_pack(cur_flags, cur_blk, cur_pc);
        dis_r     <= 1'b0;
      end else if (go_rst) begin
        mem_addr <= raddr_sel;
        mem_we   <= 1'b0;
        dis_r    <= dis_sel;
      end
      if (state == ST_RD_VEC && mem_ack) begin
        mem_addr <= mem_rdata[WORD_W-1:ADDR_W];
        new_ptr  <= mem_rdata[ADDR_W-1:0];
        mem_we   <= 1'b1;
      end
      if (state == ST_WR_SAVE && mem_ack) begin
        mem_addr <= new_ptr;
        mem_we   <= 1'b0;
      end
      if (new_ack) begin
        ctx_flags <= mem_rdata[WORD_W-1:WORD_W-FLAG_W];
        ctx_pc    <= mem_rdata[ADDR_W-1:0];
        ctx_blk   <= mem_rdata[VALID_BIT] ? mem_rdata[ADDR_W+BLK_W-1:ADDR_W] : cur_blk;
        if (dis_r) pi_clear <= first_lvl;
      end
    end
  end

  // R11: a stalled request keeps its attributes
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R3: every saved context word carries the valid bit
  a_r3_save_valid: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[VALID_BIT]);
  // R5: context outputs move only on the load edge
  a_r5_ctx_stable: assert property (@(posedge clk) disable iff (rst)
    !new_ack |=> ($stable(ctx_pc) && $stable(ctx_flags) && $stable(ctx_blk)));
  // R8: at most one level cleared, only with a load
  a_r8_clear_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pi_clear));
  a_r8_clear_with_load: assert property (@(posedge clk) disable iff (rst)
    (pi_clear != '0) |-> ctx_load);
  // R9: load happens while busy
  a_r9_busy_load: assert property (@(posedge clk) disable iff (rst)
    ctx_load |-> busy);
endmodule

// File: tb/ctxsw_engine_test.sv
`timescale 1ns/1ps
module ctxsw_engine_test;
  localparam int LV = 7;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_grant = 0, ctx_restore = 0, ctx_dismiss = 0;
  logic [17:0] int_vec_addr = '0, ctx_restore_addr = '0;
  logic [13:0] cur_flags = '0;
  logic [17:0] cur_pc = '0;
  logic [2:0]  cur_blk = '0;
  logic [LV-1:0] pi_in_prog = '0;
  logic busy, mem_req, mem_we, ctx_load;
  logic [17:0] mem_addr, ctx_pc;
  logic [35:0] mem_wdata;
  logic [35:0] mem_rdata = '0;
  logic mem_ack = 0;
  logic [13:0] ctx_flags;
  logic [2:0] ctx_blk;
  logic [LV-1:0] pi_clear;

  always #2 clk = ~clk;

  ctxsw_engine #(.LEVELS(LV)) uut (
    .clk(clk), .rst(rst), .int_grant(int_grant), .int_vec_addr(int_vec_addr),
    .ctx_restore(ctx_restore), .ctx_dismiss(ctx_dismiss), .ctx_restore_addr(ctx_restore_addr),
    .cur_flags(cur_flags), .cur_pc(cur_pc), .cur_blk(cur_blk), .pi_in_prog(pi_in_prog),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ctx_load(ctx_load), .ctx_flags(ctx_flags), .ctx_pc(ctx_pc), .ctx_blk(ctx_blk),
    .pi_clear(pi_clear)
  );

  int nchk = 0, nfail = 0;
  logic [35:0] mem [0:255];
  int ack_delay = 0, stall = 0, hold_err = 0, nlog = 0;
  logic [17:0] log_addr [0:15];
  logic        log_we   [0:15];
  logic [35:0] log_wd   [0:15];
  logic [17:0] last_addr = '0;

  // Memory model with programmable acknowledge delay.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (stall > 0 && mem_addr !== last_addr) hold_err++;
      last_addr = mem_addr;
      if (stall >= ack_delay) begin
        mem_ack = 1'b1;
        if (nlog < 16) begin
          log_addr[nlog] = mem_addr; log_we[nlog] = mem_we; log_wd[nlog] = mem_wdata;
        end
        nlog++;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else mem_rdata = mem[mem_addr[7:0]];
        stall = 0;
      end else begin
        stall++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_load(output bit seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (ctx_load) seen = 1;
    end
  endtask

  function automatic logic [35:0] cword(input logic [13:0] f, input logic v,
                                        input logic [2:0] b, input logic [17:0] p);
    return {f, v, b, p};
  endfunction

  task automatic pulse_grant(input logic [17:0] va);
    int_vec_addr = va; int_grant = 1;
    @(negedge clk);
    int_grant = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ctx_load", ctx_load, 0);
    chk("R1 pi_clear", pi_clear, 0);
  endtask

  task automatic t_swap(input logic [17:0] va, input logic [17:0] sp, input logic [17:0] np,
                        input logic [35:0] nw, input int dly);
    bit seen;
    logic [2:0] exp_blk;
    ack_delay = dly; nlog = 0;
    mem[va[7:0]] = {sp, np};
    mem[np[7:0]] = nw;
    cur_flags = 14'h2A5C; cur_pc = 18'h1F00D; cur_blk = 3'd5;
    pulse_grant(va);
    chk("R9 busy after grant", busy, 1);
    wait_load(seen);
    chk("R5 load seen", seen, 1);
    chk("R9 busy in apply", busy, 1);
    chk("R2 vec addr", log_addr[0], va);
    chk("R2 vec is read", log_we[0], 0);
    chk("R3 save addr", log_addr[1], sp);
    chk("R3 save is write", log_we[1], 1);
    chk("R3 save data", log_wd[1], cword(14'h2A5C, 1'b1, 3'd5, 18'h1F00D));
    chk("R4 new addr", log_addr[2], np);
    chk("R4 new is read", log_we[2], 0);
    chk("R5 pc", ctx_pc, nw[17:0]);
    chk("R5 flags", ctx_flags, nw[35:22]);
    exp_blk = nw[21] ? nw[20:18] : 3'd5;
    chk("R6 blk", ctx_blk, exp_blk);
    chk("R8 no clear on swap", pi_clear, 0);
    @(negedge clk);
    chk("R5 load one cycle", ctx_load, 0);
    chk("R9 idle not busy", busy, 0);
    chk("R5 pc held", ctx_pc, nw[17:0]);
    chk("R11 stall hold", hold_err, 0);
  endtask

  task automatic t_restore(input logic [17:0] ra, input logic [35:0] w, input logic dis,
                           input logic [LV-1:0] ip, input logic [LV-1:0] exp_clr);
    bit seen;
    ack_delay = 1; nlog = 0;
    mem[ra[7:0]] = w;
    cur_blk = 3'd2; pi_in_prog = ip;
    ctx_restore_addr = ra; ctx_dismiss = dis; ctx_restore = 1;
    @(negedge clk);
    ctx_restore = 0; ctx_dismiss = 0;
    wait_load(seen);
    chk("R7 load seen", seen, 1);
    chk("R7 single read", nlog, 1);
    chk("R7 read addr", log_addr[0], ra);
    chk("R7 pc", ctx_pc, w[17:0]);
    chk("R6 blk on restore", ctx_blk, w[21] ? w[20:18] : 3'd2);
    chk("R8 clear mask", pi_clear, exp_clr);
    @(negedge clk);
    chk("R8 clear only in load", pi_clear, 0);
  endtask

  task automatic t_overlap();
    bit seen;
    ack_delay = 3; nlog = 0;
    mem[8'h40] = {18'h00050, 18'h00060};
    mem[8'h60] = cword(14'h0011, 1'b1, 3'd1, 18'h00777);
    mem[8'h44] = {18'h00054, 18'h00064};
    mem[8'h64] = cword(14'h0022, 1'b1, 3'd6, 18'h00888);
    cur_blk = 3'd0;
    pulse_grant(18'h00040);
    repeat (3) @(negedge clk);
    pulse_grant(18'h00044);
    wait_load(seen);
    chk("R10 first load pc", ctx_pc, 18'h00777);
    wait_load(seen);
    chk("R10 second load seen", seen, 1);
    chk("R10 second vector addr", log_addr[3], 18'h00044);
    chk("R10 second save addr", log_addr[4], 18'h00054);
    chk("R10 second pc", ctx_pc, 18'h00888);
    chk("R6 second blk", ctx_blk, 3'd6);
    chk("R11 stall hold", hold_err, 0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_swap(18'h00010, 18'h00020, 18'h00030, cword(14'h1234, 1'b1, 3'd3, 18'h2ABCD), 0);
    t_swap(18'h00011, 18'h00021, 18'h00031, cword(14'h0F0F, 1'b0, 3'd7, 18'h00123), 2);
    t_restore(18'h00070, cword(14'h0001, 1'b1, 3'd4, 18'h00ABC), 1'b0, 7'b0000110, 7'b0000000);
    t_restore(18'h00071, cword(14'h0002, 1'b0, 3'd6, 18'h00DEF), 1'b1, 7'b0010100, 7'b0000100);
    t_restore(18'h00072, cword(14'h0003, 1'b1, 3'd1, 18'h00111), 1'b1, 7'b0000000, 7'b0000000);
    t_overlap();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule